// File: doc/BRIEF.md
# Registered Two-Way Bus Transceiver

This block links two parallel buses, called A and B, through two one-way paths. The A-to-B path carries data from the A bus onto the B bus. The B-to-A path carries data the other way. Each path has its own capture register, its own capture strobe, its own drive enable and its own source select. A path either forwards the live value of the opposite bus or replays what its register last captured.

Each bus port is modelled as three plain signals: an input, an output and an output enable. There are no tri-state pins. A capture register samples the resolved value of the bus it watches. When that bus is being driven by this block, the resolved value is the value the block drives. Otherwise it is the external input. Because of this, one capture can fill both registers with the same word.

When both paths are enabled and both select live data, each bus would simply echo the other. That loop is modelled as an internal keeper word, which holds the bus value seen just before the loop formed. Everything runs on one system clock. Capture strobes act on their rising edge, as seen at that clock.

Top module: `xcvr_bidir_reg`

## Requirements
- R1: A synchronous active-low reset clears both capture registers to zero. The keeper word is also cleared.
- R2: A rising edge on `a_cap_stb` loads the resolved A bus into the A-to-B register at that clock edge, and a rising edge on `b_cap_stb` loads the resolved B bus into the B-to-A register. Both loads happen whatever the select and enable inputs are.
- R3: `b_drive` is active high and drives the B bus, and `a_drive_n` is active low and drives the A bus. Each `*_bus_oe` output shows whether that bus is driven. A bus that is not driven outputs zero.
- R4: A select input at 0 passes the live value of the opposite bus. A select at 1 passes that path's capture register.
- R5: If B is driven with live A data (`b_drive`=1, `b_from_reg`=0, A not driven), a `b_cap_stb` edge loads `a_bus_i` into the B-to-A register, so A is stored in both registers. The mirror case stores B in both registers.
- R6: With both buses driven and both selects at 0, both outputs show the keeper word. The keeper word is the A bus value of the cycle before the loop formed. It stays unchanged for as long as the loop lasts, whatever happens on the inputs.
- R7: With neither bus driven, both outputs are zero and both enables are low. Strobe edges still load each register from its own bus input.
- R8: With both buses driven and both selects at 1, the B bus shows the A-to-B register and the A bus shows the B-to-A register, in the same cycle.
- R9: When both strobes rise at one clock edge and a driven bus replays a register, the other register receives the old register value. Staggered edges carry the new value into both. With live selection, edges at the same time fill both registers with the same value.
- R10: A strobe held high loads only once. Its register keeps its value until the strobe falls and rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_drive_n | input | 1 | Drive enable for the A bus, active low |
| b_drive | input | 1 | Drive enable for the B bus, active high |
| b_from_reg | input | 1 | Source for B bus: 0 live A, 1 A-to-B register |
| a_from_reg | input | 1 | Source for A bus: 0 live B, 1 B-to-A register |
| a_cap_stb | input | 1 | Rising edge captures resolved A bus into A-to-B register |
| b_cap_stb | input | 1 | Rising edge captures resolved B bus into B-to-A register |
| a_bus_i | input | WIDTH | Value placed on the A bus from outside |
| a_bus_o | output | WIDTH | Value this block drives on the A bus |
| a_bus_oe | output | 1 | A bus driven by this block |
| b_bus_i | input | WIDTH | Value placed on the B bus from outside |
| b_bus_o | output | WIDTH | Value this block drives on the B bus |
| b_bus_oe | output | 1 | B bus driven by this block |

## Verification
Both capture registers can load at the same clock edge while one of the driven buses is being fed by one of those same registers. In that case, what each register receives depends on whether the value it samples is old or new. The bench first sets the two registers to distinct words. It then raises both strobes in one cycle while the B bus replays the A-to-B register, and repeats the sequence with the two edges one cycle apart. It judges both runs by switching to stored-both mode and reading what each bus replays. The same-edge run must return the old word on A, and the staggered run must return the new word on both buses.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [2:0] {
    XM_ISOLATE = 3'd0,
    XM_TO_B    = 3'd1,
    XM_TO_A    = 3'd2,
    XM_BOTH    = 3'd3,
    XM_LOOP    = 3'd4
  } xfer_mode_e;

  function automatic xfer_mode_e decode_mode(input logic drv_a, input logic drv_b,
                                             input logic reg_a, input logic reg_b);
    xfer_mode_e m;
    case ({drv_a, drv_b})
      2'b00:   m = XM_ISOLATE;
      2'b01:   m = XM_TO_B;
      2'b10:   m = XM_TO_A;
      default: m = (reg_a || reg_b) ? XM_BOTH : XM_LOOP;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/xcvr_rise_det.sv
module xcvr_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  // During reset the previous level tracks the input, so a strobe that is
  // already high at release is not taken as an edge.
  always_ff @(posedge clk) begin
    lvl_q <= lvl;
  end

  assign rise = rst_n & lvl & ~lvl_q;
endmodule

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/xcvr_route.sv
module xcvr_route
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  xfer_mode_e       mode,
  input  logic             b_from_reg,
  input  logic             a_from_reg,
  input  logic [WIDTH-1:0] a_bus_i,
  input  logic [WIDTH-1:0] b_bus_i,
  input  logic [WIDTH-1:0] store_ab,
  input  logic [WIDTH-1:0] store_ba,
  input  logic [WIDTH-1:0] keep,
  output logic [WIDTH-1:0] a_val,
  output logic [WIDTH-1:0] b_val,
  output logic [WIDTH-1:0] a_seen,
  output logic [WIDTH-1:0] b_seen
);
  // Each case spells out both buses, so no output feeds back into itself.
  always_comb begin
    a_val  = '0;
    b_val  = '0;
    a_seen = a_bus_i;
    b_seen = b_bus_i;
    case (mode)
      XM_TO_B: begin
        b_val  = b_from_reg ? store_ab : a_bus_i;
        b_seen = b_val;
      end
      XM_TO_A: begin
        a_val  = a_from_reg ? store_ba : b_bus_i;
        a_seen = a_val;
      end
      XM_BOTH: begin
        // At least one side replays a register; the other may echo it.
        b_val  = b_from_reg ? store_ab : store_ba;
        a_val  = a_from_reg ? store_ba : store_ab;
        a_seen = a_val;
        b_seen = b_val;
      end
      XM_LOOP: begin
        a_val  = keep;
        b_val  = keep;
        a_seen = keep;
        b_seen = keep;
      end
      default: begin
        a_val = '0;
        b_val = '0;
      end
    endcase
  end
endmodule

// File: rtl/xcvr_bidir_reg.sv
module xcvr_bidir_reg
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_drive_n,
  input  logic             b_drive,
  input  logic             b_from_reg,
  input  logic             a_from_reg,
  input  logic             a_cap_stb,
  input  logic             b_cap_stb,
  input  logic [WIDTH-1:0] a_bus_i,
  output logic [WIDTH-1:0] a_bus_o,
  output logic             a_bus_oe,
  input  logic [WIDTH-1:0] b_bus_i,
  output logic [WIDTH-1:0] b_bus_o,
  output logic             b_bus_oe
);
  localparam int NPATH = 2;

  logic [NPATH-1:0] stb;
  logic [NPATH-1:0] rise;
  logic [WIDTH-1:0] seen  [NPATH];
  logic [WIDTH-1:0] store [NPATH];

  logic [WIDTH-1:0] a_seen, b_seen;
  logic [WIDTH-1:0] store_ab_q, store_ba_q;
  logic [WIDTH-1:0] keep_q;
  logic [WIDTH-1:0] a_val, b_val;
  xfer_mode_e       mode;

  assign mode = decode_mode(~a_drive_n, b_drive, a_from_reg, b_from_reg);

  // Path 0 is A-to-B (samples A), path 1 is B-to-A (samples B).
  assign stb     = {b_cap_stb, a_cap_stb};
  assign seen[0] = a_seen;
  assign seen[1] = b_seen;

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    xcvr_rise_det u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (stb[p]),
      .rise (rise[p])
    );
    xcvr_store_reg #(.WIDTH(WIDTH)) u_store (
      .clk  (clk),
      .rst_n(rst_n),
      .load (rise[p]),
      .d    (seen[p]),
      .q    (store[p])
    );
  end

  assign store_ab_q = store[0];
  assign store_ba_q = store[1];

  // Keeper: follows the A bus until the echo loop forms, then freezes.
  always_ff @(posedge clk) begin
    if (!rst_n)              keep_q <= '0;
    else if (mode != XM_LOOP) keep_q <= a_seen;
  end

  xcvr_route #(.WIDTH(WIDTH)) u_route (
    .mode      (mode),
    .b_from_reg(b_from_reg),
    .a_from_reg(a_from_reg),
    .a_bus_i   (a_bus_i),
    .b_bus_i   (b_bus_i),
    .store_ab  (store_ab_q),
    .store_ba  (store_ba_q),
    .keep      (keep_q),
    .a_val     (a_val),
    .b_val     (b_val),
    .a_seen    (a_seen),
    .b_seen    (b_seen)
  );

  assign a_bus_o  = a_val;
  assign b_bus_o  = b_val;
  assign a_bus_oe = ~a_drive_n;
  assign b_bus_oe = b_drive;
endmodule

// File: rtl/xcvr_bidir_reg_chk.sv
module xcvr_bidir_reg_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             b_from_reg,
  input logic             a_from_reg,
  input logic             a_cap_stb,
  input logic             b_cap_stb,
  input logic [WIDTH-1:0] a_bus_i,
  input logic [WIDTH-1:0] b_bus_i,
  input logic [WIDTH-1:0] a_bus_o,
  input logic [WIDTH-1:0] b_bus_o,
  input logic             a_bus_oe,
  input logic             b_bus_oe,
  input logic [WIDTH-1:0] a_seen,
  input logic [WIDTH-1:0] b_seen,
  input logic [WIDTH-1:0] store_ab_q,
  input logic [WIDTH-1:0] store_ba_q
);
  logic loop_now;
  assign loop_now = a_bus_oe && b_bus_oe && !a_from_reg && !b_from_reg;

  p_load_ab_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_cap_stb) |=> store_ab_q == $past(a_seen));

  p_load_ba_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_cap_stb) |=> store_ba_q == $past(b_seen));

  p_hold_ab_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(a_cap_stb) |=> $stable(store_ab_q));

  p_hold_ba_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(b_cap_stb) |=> $stable(store_ba_q));

  p_live_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (b_bus_oe && !a_bus_oe && !b_from_reg) |-> b_bus_o == b_bus_i || b_bus_o == a_bus_i);

  p_a_in_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(b_cap_stb) && b_bus_oe && !a_bus_oe && !b_from_reg) |=> store_ba_q == $past(a_bus_i));

  p_loop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_now && $past(loop_now)) |-> ($stable(a_bus_o) && a_bus_o == b_bus_o));

  p_isolate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_bus_oe && !b_bus_oe) |-> (a_bus_o == '0 && b_bus_o == '0));

  p_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (a_bus_oe && b_bus_oe && a_from_reg && b_from_reg)
      |-> (a_bus_o == store_ba_q && b_bus_o == store_ab_q));
endmodule

bind xcvr_bidir_reg xcvr_bidir_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .b_from_reg(b_from_reg),
  .a_from_reg(a_from_reg),
  .a_cap_stb (a_cap_stb),
  .b_cap_stb (b_cap_stb),
  .a_bus_i   (a_bus_i),
  .b_bus_i   (b_bus_i),
  .a_bus_o   (a_bus_o),
  .b_bus_o   (b_bus_o),
  .a_bus_oe  (a_bus_oe),
  .b_bus_oe  (b_bus_oe),
  .a_seen    (a_seen),
  .b_seen    (b_seen),
  .store_ab_q(store_ab_q),
  .store_ba_q(store_ba_q)
);

// File: tb/xcvr_bidir_reg_test.sv
module xcvr_bidir_reg_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  typedef struct packed {
    logic         a_drive_n;
    logic         b_drive;
    logic         b_from_reg;
    logic         a_from_reg;
    logic         pa;
    logic         pb;
    logic [W-1:0] ain;
    logic [W-1:0] bin;
    logic         exp_aoe;
    logic         exp_boe;
    logic [W-1:0] exp_a;
    logic [W-1:0] exp_b;
    logic [7:0]   rq;
  } vec_t;

  localparam int NV = 14;
  // Expected outputs are those seen after the strobe edge of each step.
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,8'h11,8'h22,1'b0,1'b0,8'h00,8'h00,8'd7}, // R7 isolate, both load
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,8'h33,8'h44,1'b0,1'b1,8'h00,8'h11,8'd4}, // R4 stored A->B
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,8'h55,8'h44,1'b0,1'b1,8'h00,8'h55,8'd4}, // R4 live A->B
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,8'h66,1'b1,1'b0,8'h22,8'h00,8'd3}, // R3 A active low, stored
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h77,1'b1,1'b0,8'h77,8'h00,8'd4}, // R4 live B->A
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,8'h5A,8'h00,1'b0,1'b1,8'h00,8'h5A,8'd5}, // R5 A in both, R9 same edge live
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,8'h00,8'h00,1'b1,1'b1,8'h5A,8'h5A,8'd5}, // R5 both hold A
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,8'h00,8'hA5,1'b1,1'b0,8'hA5,8'h00,8'd5}, // R5 B in both
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,8'h00,8'h00,1'b1,1'b1,8'hA5,8'hA5,8'd5}, // R5 both hold B
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,8'h3C,8'hC3,1'b0,1'b0,8'h00,8'h00,8'd2}, // R2 distinct loads
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,8'h00,8'h00,1'b1,1'b1,8'hC3,8'h3C,8'd8}, // R8 stored swap
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,8'h96,8'h00,1'b0,1'b1,8'h00,8'h96,8'd4}, // R4 lead-in to loop
    '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,8'hFF,8'h0F,1'b1,1'b1,8'h96,8'h96,8'd6}, // R6 loop holds, loads
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,8'h00,8'h00,1'b1,1'b1,8'h96,8'h96,8'd2}  // R2 loop value stored
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         a_drive_n, b_drive, b_from_reg, a_from_reg;
  logic         a_cap_stb, b_cap_stb;
  logic [W-1:0] a_bus_i, b_bus_i, a_bus_o, b_bus_o;
  logic         a_bus_oe, b_bus_oe;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xcvr_bidir_reg #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n),
    .a_drive_n(a_drive_n), .b_drive(b_drive),
    .b_from_reg(b_from_reg), .a_from_reg(a_from_reg),
    .a_cap_stb(a_cap_stb), .b_cap_stb(b_cap_stb),
    .a_bus_i(a_bus_i), .a_bus_o(a_bus_o), .a_bus_oe(a_bus_oe),
    .b_bus_i(b_bus_i), .b_bus_o(b_bus_o), .b_bus_oe(b_bus_oe)
  );

  task automatic check(input logic aoe, input logic boe, input logic [W-1:0] ea,
                       input logic [W-1:0] eb, input int rq);
    total++;
    if (a_bus_oe !== aoe || b_bus_oe !== boe || a_bus_o !== ea || b_bus_o !== eb) begin
      bad++;
      $display("FAIL R%0d: oe=%b%b a=%h b=%h expected oe=%b%b a=%h b=%h",
               rq, a_bus_oe, b_bus_oe, a_bus_o, b_bus_o, aoe, boe, ea, eb);
    end
  endtask

  task automatic set_ctl(input logic dan, input logic db, input logic bfr, input logic afr,
                         input logic [W-1:0] ain, input logic [W-1:0] bin);
    a_drive_n = dan; b_drive = db; b_from_reg = bfr; a_from_reg = afr;
    a_bus_i = ain; b_bus_i = bin;
  endtask

  // Called at a negedge: drives, pulses strobes over one edge, checks, idles a cycle.
  task automatic run_vec(input vec_t v);
    set_ctl(v.a_drive_n, v.b_drive, v.b_from_reg, v.a_from_reg, v.ain, v.bin);
    a_cap_stb = v.pa; b_cap_stb = v.pb;
    @(posedge clk); @(negedge clk);
    a_cap_stb = 1'b0; b_cap_stb = 1'b0;
    check(v.exp_aoe, v.exp_boe, v.exp_a, v.exp_b, int'(v.rq));
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    set_ctl(1'b1, 1'b0, 1'b0, 1'b0, '0, '0);
    a_cap_stb = 1'b0; b_cap_stb = 1'b0;
    @(negedge clk);
    do_reset();

    // R1: registers clear; replay both in stored-both mode
    set_ctl(1'b0, 1'b1, 1'b1, 1'b1, 8'hEE, 8'hEE);
    #1 check(1'b1, 1'b1, 8'h00, 8'h00, 1);
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R9 same edge while B replays the A-to-B register
    run_vec('{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,8'h11,8'h22,1'b0,1'b0,8'h00,8'h00,8'd9});
    run_vec('{1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,8'h44,8'h00,1'b0,1'b1,8'h00,8'h44,8'd9});
    run_vec('{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,8'h00,8'h00,1'b1,1'b1,8'h11,8'h44,8'd9}); // old word on A

    // R9 staggered edges carry the new word into both
    run_vec('{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,8'h11,8'h22,1'b0,1'b0,8'h00,8'h00,8'd9});
    run_vec('{1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,8'h44,8'h00,1'b0,1'b1,8'h00,8'h44,8'd9});
    run_vec('{1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,8'h99,8'h00,1'b0,1'b1,8'h00,8'h44,8'd9});
    run_vec('{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,8'h00,8'h00,1'b1,1'b1,8'h44,8'h44,8'd9});

    // R10: strobe held high loads once only
    set_ctl(1'b1, 1'b0, 1'b0, 1'b0, 8'h12, 8'h00);
    a_cap_stb = 1'b1;
    @(posedge clk); @(negedge clk);
    a_bus_i = 8'h34;
    repeat (3) @(posedge clk);
    @(negedge clk);
    set_ctl(1'b1, 1'b1, 1'b1, 1'b0, 8'h56, 8'h00);
    #1 check(1'b0, 1'b1, 8'h00, 8'h12, 10);
    @(negedge clk);
    a_cap_stb = 1'b0;
    @(negedge clk);

    // R6: loop value survives changing inputs over several cycles
    run_vec('{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,8'h6B,8'h00,1'b0,1'b1,8'h00,8'h6B,8'd6});
    set_ctl(1'b0, 1'b1, 1'b0, 1'b0, 8'h01, 8'h02);
    repeat (4) begin
      @(negedge clk);
      a_bus_i = a_bus_i + 8'h11;
      b_bus_i = b_bus_i + 8'h22;
    end
    #1 check(1'b1, 1'b1, 8'h6B, 8'h6B, 6);
    @(negedge clk);

    // R1: mid-run reset clears loaded registers
    set_ctl(1'b1, 1'b0, 1'b0, 1'b0, '0, '0);
    do_reset();
    set_ctl(1'b0, 1'b1, 1'b1, 1'b1, 8'hEE, 8'hEE);
    #1 check(1'b1, 1'b1, 8'h00, 8'h00, 1);
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule